// File: doc/BRIEF.md
# Line-Card Control and Status Register Bank

This block is a byte-wide register bank that sits behind one chip select on a processor's local bus. Software reads a five-bit backplane slot number, a per-port flag showing that a line port has lost its sync, and the level of each framer's timeslot-enable pin. Software writes one fixed/adaptive timing bit per port. The bus interface has an active-low chip select, an active-low read strobe and an active-low write strobe. A write is captured on the rising clock edge. Read data is returned combinationally while the read strobe is held.

Each of the four ports also has a timing-clock pad, and its direction depends on that port's line mode. In network-side mode the block drives the pad with the port's timing bit. In terminal-side mode the pad is released so that the framer can drive its sync onto it. The block does not hold the pad itself. It exposes a data-out and an output-enable per port, and a pad cell outside the block does the tristating. All asynchronous status inputs and the mode inputs pass through a two-flop synchronizer.

Top module: `lc_csr_bank`

## Requirements
- R1: After reset all four timing bits are 0, every pad output-enable is 0, every pad data-out is 0, and rdata is 0.
- R2: Word 0 (addr[3:2]=0) reads the slot number in bits 4:0 and 0 in bits 7:5.
- R3: Word 1 (addr[3:2]=1) reads the sync-loss flags in bits 7:4 and the timing bits in bits 3:0. Bit 4 and bit 0 belong to port 1, and bit 7 and bit 3 belong to port 4.
- R4: Word 2 (addr[3:2]=2) reads the four timeslot-enable pins in bits 3:0, with bit 0 for framer 1, and 0 in bits 7:4.
- R5: A write updates the timing bits from wdata[3:0] only when cs_n and wr_n are both low at a rising edge and addr[3:2]=1. Writes to any other word, and wdata[7:4], have no effect.
- R6: addr[1:0] and all address bits above bit 3 are ignored, so the bank repeats every 16 bytes. Word 3 reads 0 and ignores writes.
- R7: A port whose NT-mode input is high has its pad output-enable set and its pad data-out equal to its timing bit. A port whose NT-mode input is low has output-enable 0 and data-out 0. Mode changes reach the pad after two rising edges.
- R8: A change on the slot, sync-loss or timeslot-enable inputs becomes readable after the second rising edge following the change, and not after the first.
- R9: rdata is 0 whenever cs_n or rd_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 8 | Byte address on the bus |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| slot_id | input | 5 | Backplane slot number, asynchronous |
| sync_lost | input | 4 | Per-port sync-loss flags, asynchronous |
| ts_en | input | 4 | Per-framer timeslot-enable pin levels, asynchronous |
| nt_mode | input | 4 | Per-port line mode, 1 for network side |
| tclk_out | output | 4 | Pad data-out per port |
| tclk_oe | output | 4 | Pad output-enable per port |

## Verification
The status inputs are driven with alternating and walking patterns. This shows that each bit lands in its own register position and that no bit is swapped between ports. Timing-bit writes use distinct nibbles with the upper nibble set, and are sent to every word and to aliased addresses. This separates a correct decode from one that ignores the word index or the low address bits. Mode inputs are toggled per port while the timing bits are held at a known value. This shows that the pad direction follows the mode input and that the data-out follows the timing bit. Reads made one and two edges after a status change show that the synchronizer depth is correct.

// File: rtl/lc_csr_pkg.sv
package lc_csr_pkg;
  localparam int DATA_W   = 8;
  localparam int NPORT    = 4;
  localparam int SLOT_W   = 5;
  localparam int WORD_LSB = 2;
  localparam int WORD_W   = 2;
  localparam int NWORD    = 1 << WORD_W;

  typedef enum logic [WORD_W-1:0] {
    W_SLOT   = 2'd0,
    W_TIMING = 2'd1,
    W_TSEN   = 2'd2,
    W_SPARE  = 2'd3
  } word_e;
endpackage

// File: rtl/lc_csr_sync.sv
module lc_csr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/lc_csr_decode.sv
module lc_csr_decode
  import lc_csr_pkg::*;
(
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [WORD_W-1:0] word_idx,
  output logic              rd_en,
  output logic [NWORD-1:0]  rd_sel,
  output logic              wr_timing
);
  always_comb begin
    rd_en  = !cs_n && !rd_n;
    rd_sel = '0;
    if (rd_en) rd_sel[word_idx] = 1'b1;
    wr_timing = !cs_n && !wr_n && (word_e'(word_idx) == W_TIMING);
  end
endmodule

// File: rtl/lc_csr_tclk.sv
module lc_csr_tclk
  import lc_csr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] nt_mode,
  input  logic [NPORT-1:0] fix_bits,
  output logic [NPORT-1:0] tclk_out,
  output logic [NPORT-1:0] tclk_oe
);
  logic [NPORT-1:0] nt_q;

  lc_csr_sync #(.W(NPORT), .STAGES(SYNC_STAGES)) u_nt_sync (
    .clk (clk), .rst_n (rst_n), .din (nt_mode), .dout (nt_q)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign tclk_oe[p]  = nt_q[p];
    assign tclk_out[p] = nt_q[p] & fix_bits[p];

    // R7: a driven pad traces back to NT mode seen two edges earlier
    p_oe_from_nt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tclk_oe[p]) |-> $past(nt_mode[p], 2));
    // R7: a released pad never carries a level
    p_released_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tclk_oe[p] |-> !tclk_out[p]);
  end
endmodule

// File: rtl/lc_csr_bank.sv
module lc_csr_bank
  import lc_csr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [SLOT_W-1:0] slot_id,
  input  logic [NPORT-1:0]  sync_lost,
  input  logic [NPORT-1:0]  ts_en,
  input  logic [NPORT-1:0]  nt_mode,
  output logic [NPORT-1:0]  tclk_out,
  output logic [NPORT-1:0]  tclk_oe
);
  localparam int WORD_MSB = WORD_LSB + WORD_W - 1;

  logic [WORD_W-1:0] word_idx;
  logic              unused_addr_bits;
  logic              rd_en, wr_timing;
  logic [NWORD-1:0]  rd_sel;
  logic [NPORT-1:0]  fix_q;
  logic [SLOT_W-1:0] slot_q;
  logic [NPORT-1:0]  lost_q, tsen_q;
  logic [DATA_W-1:0] word_val [NWORD];

  assign word_idx = addr[WORD_MSB:WORD_LSB];
  if (ADDR_W > WORD_MSB + 1) begin : g_hi
    assign unused_addr_bits = ^{addr[ADDR_W-1:WORD_MSB+1], addr[WORD_LSB-1:0], wdata[DATA_W-1:NPORT]};
  end else begin : g_nohi
    assign unused_addr_bits = ^{addr[WORD_LSB-1:0], wdata[DATA_W-1:NPORT]};
  end

  lc_csr_decode u_dec (
    .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n), .word_idx (word_idx),
    .rd_en (rd_en), .rd_sel (rd_sel), .wr_timing (wr_timing)
  );

  lc_csr_sync #(.W(SLOT_W), .STAGES(SYNC_STAGES)) u_slot_sync (
    .clk (clk), .rst_n (rst_n), .din (slot_id), .dout (slot_q)
  );
  lc_csr_sync #(.W(NPORT), .STAGES(SYNC_STAGES)) u_lost_sync (
    .clk (clk), .rst_n (rst_n), .din (sync_lost), .dout (lost_q)
  );
  lc_csr_sync #(.W(NPORT), .STAGES(SYNC_STAGES)) u_tsen_sync (
    .clk (clk), .rst_n (rst_n), .din (ts_en), .dout (tsen_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fix_q <= '0;
    else if (wr_timing) fix_q <= wdata[NPORT-1:0];
  end

  assign word_val[W_SLOT]   = DATA_W'(slot_q);
  assign word_val[W_TIMING] = {lost_q, fix_q};
  assign word_val[W_TSEN]   = DATA_W'(tsen_q);
  assign word_val[W_SPARE]  = '0;

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NWORD; w++)
      if (rd_sel[w]) rdata = rdata | word_val[w];
  end

  lc_csr_tclk #(.SYNC_STAGES(SYNC_STAGES)) u_tclk (
    .clk (clk), .rst_n (rst_n), .nt_mode (nt_mode), .fix_bits (fix_q),
    .tclk_out (tclk_out), .tclk_oe (tclk_oe)
  );

  // R5: timing bits move only on an accepted timing-word write
  p_fix_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_timing |=> $stable(fix_q));
  // R9: nothing on rdata outside a read
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> rdata == '0);
  // R2: upper slot-word bits stay clear
  p_slot_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && word_idx == W_SLOT) |-> rdata[DATA_W-1:SLOT_W] == '0);
  // R6: spare word reads empty
  p_spare_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && word_idx == W_SPARE) |-> rdata == '0);
endmodule

// File: tb/lc_csr_bank_tb.sv
module lc_csr_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic [4:0] slot_id = '0;
  logic [3:0] sync_lost = '0, ts_en = '0, nt_mode = '0;
  logic [3:0] tclk_out, tclk_oe;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  lc_csr_bank u_dut (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n),
    .addr (addr), .wdata (wdata), .rdata (rdata), .slot_id (slot_id),
    .sync_lost (sync_lost), .ts_en (ts_en), .nt_mode (nt_mode),
    .tclk_out (tclk_out), .tclk_oe (tclk_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #1 d = rdata;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    @(negedge clk);
    chk("R1 rdata idle", rdata, 8'h00);
    chk("R1 oe", {4'h0, tclk_oe}, 8'h00);
    chk("R1 out", {4'h0, tclk_out}, 8'h00);
    rd(8'h04, d); chk("R1 timing bits", d, 8'h00);
  endtask

  task automatic t_slot;
    logic [7:0] d;
    slot_id = 5'b10101; settle(3);
    rd(8'h00, d); chk("R2 slot 15", d, 8'h15);
    slot_id = 5'b11111; settle(3);
    rd(8'h00, d); chk("R2 slot 1f hi zero", d, 8'h1f);
  endtask

  task automatic t_timing;
    logic [7:0] d;
    sync_lost = 4'b0001; settle(3);
    wr(8'h04, 8'hfa);
    rd(8'h04, d); chk("R3 flags+fix", d, 8'h1a);
    rd(8'h04, d); chk("R5 write lower nibble", d[3:0], 8'h0a);
    sync_lost = 4'b1000; settle(3);
    wr(8'h04, 8'h05);
    rd(8'h04, d); chk("R3 port4 flag", d, 8'h85);
  endtask

  task automatic t_tsen;
    logic [7:0] d;
    ts_en = 4'b0110; settle(3);
    rd(8'h08, d); chk("R4 tsen", d, 8'h06);
    ts_en = 4'b1001; settle(3);
    rd(8'h08, d); chk("R4 tsen walk", d, 8'h09);
  endtask

  task automatic t_ro_ignore;
    logic [7:0] d;
    wr(8'h00, 8'hff); wr(8'h08, 8'hff); wr(8'h0c, 8'hff);
    rd(8'h04, d); chk("R5 other words ignored", d[3:0], 8'h05);
    rd(8'h00, d); chk("R5 slot unchanged", d, 8'h1f);
    cs_n = 1'b1;
    @(negedge clk); addr = 8'h04; wdata = 8'h0f; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    rd(8'h04, d); chk("R5 no write without cs", d[3:0], 8'h05);
  endtask

  task automatic t_alias;
    logic [7:0] d;
    wr(8'h37, 8'h03);
    rd(8'h05, d); chk("R6 alias write low bits", d[3:0], 8'h03);
    rd(8'hf6, d); chk("R6 alias read high bits", d[3:0], 8'h03);
    rd(8'h13, d); chk("R6 alias slot word", d, 8'h1f);
    rd(8'h0c, d); chk("R6 spare word", d, 8'h00);
  endtask

  task automatic t_idle;
    @(negedge clk); addr = 8'h00; cs_n = 1'b0; rd_n = 1'b1;
    #1 chk("R9 rd_n high", rdata, 8'h00);
    cs_n = 1'b1; rd_n = 1'b0;
    #1 chk("R9 cs_n high", rdata, 8'h00);
    rd_n = 1'b1;
  endtask

  task automatic t_nt;
    wr(8'h04, 8'h05);
    nt_mode = 4'b0011;
    @(negedge clk);
    chk("R7 not yet after one edge", {4'h0, tclk_oe}, 8'h00);
    @(negedge clk);
    chk("R7 oe", {4'h0, tclk_oe}, 8'h03);
    chk("R7 out", {4'h0, tclk_out}, 8'h01);
    wr(8'h04, 8'h0a);
    chk("R7 out follows fix", {4'h0, tclk_out}, 8'h02);
    nt_mode = 4'b1100; settle(2);
    chk("R7 oe swap", {4'h0, tclk_oe}, 8'h0c);
    chk("R7 out swap", {4'h0, tclk_out}, 8'h08);
    nt_mode = 4'b0000; settle(2);
    chk("R7 TE released", {tclk_oe, tclk_out}, 8'h00);
  endtask

  task automatic t_sync;
    logic [7:0] d;
    @(negedge clk); ts_en = 4'b0101;
    @(negedge clk);
    addr = 8'h08; cs_n = 1'b0; rd_n = 1'b0;
    #1 d = rdata; chk("R8 one edge old", d, 8'h09);
    @(negedge clk);
    #1 d = rdata; chk("R8 two edges new", d, 8'h05);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    t_reset;
    t_slot;
    t_timing;
    t_tsen;
    t_ro_ignore;
    t_alias;
    t_idle;
    t_nt;
    t_sync;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule